// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a behavioural single-port synchronous memory for use inside a larger design. Each word is built from byte lanes of eight data bits plus one parity bit. Commands are sampled on the rising clock edge. An access is started by one of two active-low address strobes: a processor strobe, which can only start reads, and a controller strobe, which can start reads or writes. The access then continues through a four-word burst. The burst sequencer makes the low address bits in linear or interleaved order, and the `order_ilv` input picks the order. When `adv_n` is high, the burst holds its current address.

Write qualification has three levels. The global write enable writes every lane. The byte-write gate admits the per-lane enables. When neither is active, the cycle is a read. Read data is registered, so a word appears one edge after its address is taken. A write cycle blanks the output. Output enable acts without the clock. A sleep input stops all edges from taking effect but keeps the stored contents. The first edge after sleep always acts as a deselect.

Data travels on separate input and output buses. The output bus carries a valid flag and reads as zero whenever the flag is low. The controller is a state machine with three states. ST_IDLE is deselected: it leaves to ST_BURST on a selected strobe and to ST_SLEEP on sleep. ST_BURST has an active burst: it stays there on continue, suspend or a new strobe, returns to ST_IDLE on a deselecting strobe, and goes to ST_SLEEP on sleep. ST_SLEEP has edges blocked: it returns to ST_IDLE on the first edge with sleep low.

Top module: `pbw_sram`

## Requirements
- R1: When `gw_n` is 0 on a write-capable cycle, every lane of the word at the access address is written from `wdata`, whatever `bwg_n` and `bw_n` are. A write-capable cycle is a selected controller-strobe start, or a continue or suspend cycle of an active burst.
- R2: When `gw_n` is 1 and `bwg_n` is 0, each lane k with `bw_n[k]` = 0 is written. Several lanes may be written in one cycle, and lanes whose enable is 1 keep their old contents.
- R3: When `gw_n` is 1 and `bwg_n` is 1, the cycle is a read whatever `bw_n` is, and memory is not changed.
- R4: Lane k holds `wdata[8k+7:8k]` together with parity bit `wdata[8*NUM_LANES+k]`, and `rdata` uses the same positions.
- R5: Read data is pipelined. When an address is taken at edge k, `rdata` and `rvalid` show that word after edge k+1. Each later burst cycle delivers one further word per edge.
- R6: The burst counter starts at 0 on a strobe and steps once for each cycle with `adv_n` = 0. When `adv_n` = 1 it holds, and the current address is repeated. The low two address bits are base XOR count when `order_ilv` = 1, and base + count modulo 4 when `order_ilv` = 0. After the fourth word the sequence wraps back to the base.
- R7: A cycle that writes any lane at edge k makes `rvalid` 0 after edge k, even if a read from edge k-1 was pending.
- R8: `oe_n` = 1 forces `rvalid` to 0 at once, without waiting for a clock edge, and does not disturb the pipeline. Returning `oe_n` to 0 shows the held word again.
- R9: While `sleep_i` is 1, edges perform no operation, stored contents are kept, and `rvalid` is 0.
- R10: The first edge with `sleep_i` = 0 after sleep acts as a deselect whatever the strobes are. `rvalid` is still 0 after the next edge.
- R11: A processor strobe (`ld_cpu_n` = 0 with `ce_n` = 0 and the chip selected) starts a read and ignores the write inputs. A processor strobe with `ce_n` = 1 is ignored, and the cycle acts as a continue or suspend.
- R12: A strobe while the chip is not selected is a deselect, and it writes nothing. `rvalid` goes to 0 one edge after the deselect edge. Cycles without a strobe while deselected do nothing. The chip is selected when `ce_n` = 0, `sel_hi` = 1 and `sel_lo_n` = 0.
- R13: `rdata` is all zeros whenever `rvalid` is 0, and `rvalid` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep: blocks all edges, keeps contents |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| ce_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| ld_cpu_n | input | 1 | Processor address strobe, active low, read only |
| ld_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address taken on a strobe |
| gw_n | input | 1 | Global write enable, active low |
| bwg_n | input | 1 | Byte-write gate, active low |
| bw_n | input | NUM_LANES | Per-lane write enables, active low |
| wdata | input | 9*NUM_LANES | Write data: bytes low, parity bits high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 9*NUM_LANES | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
A write takes effect at the edge that carries it, so a read started on any later cycle sees the new data. Read data and its valid flag are due exactly one edge after the edge that registers the address. Write blanking is due at the write edge itself, and the effect of a deselect is due one edge after it. Output enable and sleep act between edges. The bench therefore drives inputs on falling edges and samples one half period after each rising edge; for the asynchronous inputs it checks a nanosecond after changing them, with no edge in between. Burst checks walk the expected address sequence one edge at a time through the wrap.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_SLEEP = 2'd2
    } pbw_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_DESEL = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } pbw_op_e;

    localparam int unsigned PBW_BYTE_BITS = 8;
    localparam int unsigned PBW_LANE_BITS = PBW_BYTE_BITS + 1;

endpackage

// File: rtl/pbw_wr_qual.sv
module pbw_wr_qual #(
    parameter int NUM_LANES = 2
) (
    input  logic                 allow,
    input  logic                 gw_n,
    input  logic                 bwg_n,
    input  logic [NUM_LANES-1:0] bw_n,
    output logic [NUM_LANES-1:0] lane_we
);

    // global write overrides; the gate admits the per-lane enables
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        assign lane_we[k] = allow & (~gw_n | (~bwg_n & ~bw_n[k]));
    end

endmodule

// File: rtl/pbw_burst_seq.sv
module pbw_burst_seq #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              step,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_use;
    logic [CNT_W-1:0]  lo_bits;

    always_comb begin
        cnt_use = step ? cnt_q + 1'b1 : cnt_q;
        if (order_ilv) begin
            lo_bits = base_q[CNT_W-1:0] ^ cnt_use;
        end else begin
            lo_bits = base_q[CNT_W-1:0] + cnt_use;
        end
        if (load) begin
            acc_addr = load_addr;
        end else begin
            acc_addr = {base_q[ADDR_W-1:CNT_W], lo_bits};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (load) begin
                base_q <= load_addr;
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q  <= cnt_use;
            end
        end
    end

endmodule

// File: rtl/pbw_array.sv
module pbw_array #(
    parameter int ADDR_W    = 8,
    parameter int NUM_LANES = 2,
    parameter int LANE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [LANE_W*NUM_LANES-1:0] wdata,
    input  logic                        re,
    input  logic [ADDR_W-1:0]           raddr,
    output logic [LANE_W*NUM_LANES-1:0] rq
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BYTE_W = LANE_W - 1;
    localparam int PAR_LO = BYTE_W * NUM_LANES;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] wl;
        logic [LANE_W-1:0] rl_q;

        assign wl = {wdata[PAR_LO+k], wdata[k*BYTE_W +: BYTE_W]};

        always_ff @(posedge clk) begin
            if (lane_we[k]) begin
                cells[waddr] <= wl;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rl_q <= '0;
            end else if (re) begin
                rl_q <= cells[raddr];
            end
        end

        assign rq[k*BYTE_W +: BYTE_W] = rl_q[BYTE_W-1:0];
        assign rq[PAR_LO+k]           = rl_q[BYTE_W];
    end

endmodule

// File: rtl/pbw_out_stage.sv
module pbw_out_stage #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pend,
    input  logic              kill,
    input  logic              oe_n,
    input  logic              hide,
    input  logic [DATA_W-1:0] rq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic dvld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvld_q <= 1'b0;
        end else if (en) begin
            dvld_q <= pend & ~kill;
        end
    end

    always_comb begin
        rvalid = dvld_q & ~oe_n & ~hide;
        rdata  = rvalid ? rq_in : '0;
    end

endmodule

// File: rtl/pbw_sram.sv
module pbw_sram
    import pbw_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LANES = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sleep_i,
    input  logic                                 order_ilv,
    input  logic                                 ce_n,
    input  logic                                 sel_hi,
    input  logic                                 sel_lo_n,
    input  logic                                 ld_cpu_n,
    input  logic                                 ld_ctl_n,
    input  logic                                 adv_n,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic                                 gw_n,
    input  logic                                 bwg_n,
    input  logic [NUM_LANES-1:0]                 bw_n,
    input  logic [PBW_LANE_BITS*NUM_LANES-1:0]   wdata,
    input  logic                                 oe_n,
    output logic [PBW_LANE_BITS*NUM_LANES-1:0]   rdata,
    output logic                                 rvalid
);

    localparam int LANE_W = PBW_LANE_BITS;
    localparam int DATA_W = LANE_W * NUM_LANES;
    localparam int CNT_W  = $clog2(BURST_LEN);

    pbw_state_e             st_q;
    pbw_state_e             st_d;
    pbw_op_e                op_c;
    logic                   acc_go;
    logic                   desel_go;
    logic                   wr_allow;
    logic                   load_c;
    logic                   step_c;
    logic                   chip_sel;
    logic                   cpu_go;
    logic                   ctl_go;
    logic [NUM_LANES-1:0]   lane_we;
    logic                   arr_we;
    logic [ADDR_W-1:0]      acc_addr;
    logic [ADDR_W-1:0]      acc_addr_q;
    logic                   acc_rd_q;
    logic [DATA_W-1:0]      arr_q;

    assign chip_sel = ~ce_n & sel_hi & ~sel_lo_n;
    assign cpu_go   = ~ce_n & ~ld_cpu_n;
    assign ctl_go   = ~ld_ctl_n;

    // next-state and command decode
    always_comb begin
        st_d     = st_q;
        acc_go   = 1'b0;
        desel_go = 1'b0;
        wr_allow = 1'b0;
        load_c   = 1'b0;
        step_c   = 1'b0;
        if (sleep_i) begin
            st_d = ST_SLEEP;
        end else begin
            unique case (st_q)
                ST_SLEEP: begin
                    desel_go = 1'b1;
                    st_d     = ST_IDLE;
                end
                ST_IDLE, ST_BURST: begin
                    if (cpu_go) begin
                        if (chip_sel) begin
                            acc_go = 1'b1;
                            load_c = 1'b1;
                            st_d   = ST_BURST;
                        end else begin
                            desel_go = 1'b1;
                            st_d     = ST_IDLE;
                        end
                    end else if (ctl_go) begin
                        if (chip_sel) begin
                            acc_go   = 1'b1;
                            load_c   = 1'b1;
                            wr_allow = 1'b1;
                            st_d     = ST_BURST;
                        end else begin
                            desel_go = 1'b1;
                            st_d     = ST_IDLE;
                        end
                    end else if (st_q == ST_BURST) begin
                        acc_go   = 1'b1;
                        wr_allow = 1'b1;
                        step_c   = ~adv_n;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    pbw_wr_qual #(
        .NUM_LANES(NUM_LANES)
    ) u_qual (
        .allow   (wr_allow),
        .gw_n    (gw_n),
        .bwg_n   (bwg_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    assign arr_we = |lane_we;

    // operation of this cycle
    always_comb begin
        if (acc_go) begin
            op_c = arr_we ? OP_WRITE : OP_READ;
        end else if (desel_go) begin
            op_c = OP_DESEL;
        end else begin
            op_c = OP_NONE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // registered read address stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_rd_q   <= 1'b0;
            acc_addr_q <= '0;
        end else if (!sleep_i) begin
            acc_rd_q   <= (op_c == OP_READ);
            acc_addr_q <= acc_addr;
        end
    end

    pbw_burst_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (~sleep_i),
        .load      (load_c),
        .step      (step_c),
        .order_ilv (order_ilv),
        .load_addr (addr),
        .acc_addr  (acc_addr)
    );

    pbw_array #(
        .ADDR_W    (ADDR_W),
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .waddr   (acc_addr),
        .wdata   (wdata),
        .re      (~sleep_i & acc_rd_q),
        .raddr   (acc_addr_q),
        .rq      (arr_q)
    );

    pbw_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (~sleep_i),
        .pend   (acc_rd_q),
        .kill   ((op_c == OP_WRITE) | (st_q == ST_SLEEP)),
        .oe_n   (oe_n),
        .hide   (sleep_i | (st_q == ST_SLEEP)),
        .rq_in  (arr_q),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

endmodule

// File: rtl/pbw_sram_chk.sv
module pbw_sram_chk
    import pbw_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              oe_n,
    input logic              ce_n,
    input logic              ld_cpu_n,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input pbw_state_e        st_q,
    input pbw_op_e           op_c,
    input logic              arr_we
);

    logic rd_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= ~sleep_i & (op_c == OP_READ);
        end
    end

    // R5
    pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && !sleep_i && st_q != ST_SLEEP && op_c != OP_WRITE)
        |=> (rvalid || oe_n || sleep_i));

    // R7
    write_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && op_c == OP_WRITE) |=> !rvalid);

    // R8
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rvalid);

    // R9
    sleep_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (!arr_we && !rvalid));

    // R10
    wake_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && !sleep_i) |=> (st_q == ST_IDLE && !rvalid));

    // R11
    cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && st_q != ST_SLEEP && !ce_n && !ld_cpu_n) |-> !arr_we);

    // R12
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && op_c == OP_DESEL) |=> ##1 !rvalid);

    // R13
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

endmodule

bind pbw_sram pbw_sram_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_i  (sleep_i),
    .oe_n     (oe_n),
    .ce_n     (ce_n),
    .ld_cpu_n (ld_cpu_n),
    .rvalid   (rvalid),
    .rdata    (rdata),
    .st_q     (st_q),
    .op_c     (op_c),
    .arr_we   (arr_we)
);

// File: tb/tb_pbw_sram.sv
`timescale 1ns/1ps
module tb_pbw_sram;

    localparam int AW    = 8;
    localparam int NL    = 2;
    localparam int W     = 9 * NL;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep_i, order_ilv, ce_n, sel_hi, sel_lo_n;
    logic          ld_cpu_n, ld_ctl_n, adv_n, gw_n, bwg_n, oe_n;
    logic [AW-1:0] addr;
    logic [NL-1:0] bw_n;
    logic [W-1:0]  wdata;
    logic [W-1:0]  rdata;
    logic          rvalid;

    logic [W-1:0]  mdl [DEPTH];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #2.5 clk = ~clk;

    pbw_sram #(.ADDR_W(AW), .NUM_LANES(NL), .BURST_LEN(4)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .order_ilv(order_ilv),
        .ce_n(ce_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .adv_n(adv_n),
        .addr(addr), .gw_n(gw_n), .bwg_n(bwg_n), .bw_n(bw_n),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_idle();
        sleep_i = 0; ce_n = 0; sel_hi = 1; sel_lo_n = 0;
        ld_cpu_n = 1; ld_ctl_n = 1; adv_n = 1;
        gw_n = 1; bwg_n = 1; bw_n = '1; oe_n = 0; addr = '0; wdata = '0;
    endtask

    // bit mask of the lanes enabled by the write rules (R1, R2, R4)
    function automatic logic [W-1:0] lane_mask(input logic g, input logic bg, input logic [NL-1:0] b);
        logic [W-1:0] m = '0;
        for (int k = 0; k < NL; k++) begin
            if (!g || (!bg && !b[k])) begin
                m[k*8 +: 8] = 8'hFF;
                m[8*NL + k] = 1'b1;
            end
        end
        return m;
    endfunction

    task automatic mdl_apply(input logic [AW-1:0] a, input logic [W-1:0] d,
                             input logic g, input logic bg, input logic [NL-1:0] b);
        logic [W-1:0] m = lane_mask(g, bg, b);
        mdl[a] = (mdl[a] & ~m) | (d & m);
    endtask

    task automatic desel_tick();
        ld_ctl_n = 0; ce_n = 1;
        tick();
        drive_idle();
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                            input logic g, input logic bg, input logic [NL-1:0] b);
        ld_ctl_n = 0; addr = a; wdata = d; gw_n = g; bwg_n = bg; bw_n = b;
        tick();
        mdl_apply(a, d, g, bg, b);
        desel_tick();
    endtask

    task automatic read_single(input logic [AW-1:0] a, input string tag);
        ld_ctl_n = 0; addr = a;
        tick();
        chk({tag, " R5 not before one edge"}, {31'd0, rvalid}, 32'd0);
        desel_tick();
        chk({tag, " R5 valid"}, {31'd0, rvalid}, 32'd1);
        chk({tag, " R5 data"}, rdata, mdl[a]);
        tick();
        chk({tag, " R12 valid drops"}, {31'd0, rvalid}, 32'd0);
    endtask

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] b, input int i, input logic ilv);
        logic [1:0] lo = ilv ? (b[1:0] ^ 2'(i)) : (b[1:0] + 2'(i));
        return {b[AW-1:2], lo};
    endfunction

    task automatic t_reset();
        chk("R13 reset valid", {31'd0, rvalid}, 32'd0);
        chk("R13 reset data", rdata, 32'd0);
    endtask

    task automatic t_global_write();
        do_write(8'h10, 18'h2A5A5, 1'b0, 1'b0, 2'b11);
        read_single(8'h10, "R1 global write");
        do_write(8'h11, 18'h15A3C, 1'b0, 1'b1, 2'b00);
        read_single(8'h11, "R1 global write gate high");
    endtask

    task automatic t_byte_write();
        do_write(8'h20, 18'h00000, 1'b0, 1'b1, 2'b11);
        do_write(8'h20, 18'h3FFFF, 1'b1, 1'b0, 2'b01);
        chk("R4 lane1 position", mdl[8'h20], 32'h2FF00);
        read_single(8'h20, "R2 R4 lane1 only");
        do_write(8'h20, 18'h1C3C3, 1'b1, 1'b0, 2'b10);
        read_single(8'h20, "R2 R4 lane0 only");
        do_write(8'h21, 18'h3ABCD, 1'b1, 1'b0, 2'b00);
        read_single(8'h21, "R2 both lanes");
    endtask

    task automatic t_gate_blocks();
        do_write(8'h20, 18'h12345, 1'b1, 1'b1, 2'b00);
        read_single(8'h20, "R3 gate high is read");
    endtask

    task automatic t_burst(input logic [AW-1:0] b, input logic ilv, input string tag);
        order_ilv = ilv;
        ld_ctl_n = 0; addr = b;
        tick();
        ld_ctl_n = 1; adv_n = 0;
        for (int i = 1; i <= 4; i++) begin
            tick();
            chk({tag, " R6 valid"}, {31'd0, rvalid}, 32'd1);
            chk({tag, " R6 word"}, rdata, mdl[burst_addr(b, i - 1, ilv)]);
        end
        desel_tick();
        chk({tag, " R6 wrap word"}, rdata, mdl[b]);
        tick();
        chk({tag, " R12 end"}, {31'd0, rvalid}, 32'd0);
    endtask

    task automatic t_suspend();
        order_ilv = 0;
        ld_ctl_n = 0; addr = 8'h41;
        tick();
        ld_ctl_n = 1; adv_n = 1;
        tick();
        chk("R6 suspend first", rdata, mdl[8'h41]);
        adv_n = 0;
        tick();
        chk("R6 suspend repeats", rdata, mdl[8'h41]);
        desel_tick();
        chk("R6 advance after suspend", rdata, mdl[8'h42]);
        tick();
    endtask

    task automatic t_write_blank();
        ld_ctl_n = 0; addr = 8'h40;
        tick();
        ld_ctl_n = 1; adv_n = 1; gw_n = 0; wdata = 18'h0BEEF;
        tick();
        mdl[8'h40] = 18'h0BEEF;
        chk("R7 write blanks output", {31'd0, rvalid}, 32'd0);
        desel_tick();
        chk("R7 still blank", {31'd0, rvalid}, 32'd0);
        read_single(8'h40, "R1 write on suspend cycle");
    endtask

    task automatic t_oe();
        ld_ctl_n = 0; addr = 8'h10;
        tick();
        ld_ctl_n = 0; ce_n = 1; oe_n = 1;
        tick();
        chk("R8 oe high hides", {31'd0, rvalid}, 32'd0);
        chk("R13 hidden data zero", rdata, 32'd0);
        oe_n = 0;
        #1;
        chk("R8 oe low shows", {31'd0, rvalid}, 32'd1);
        chk("R8 oe low data", rdata, mdl[8'h10]);
        drive_idle();
        tick();
    endtask

    task automatic t_cpu();
        ld_cpu_n = 0; addr = 8'h10; gw_n = 0; wdata = 18'h3FFFF;
        tick();
        drive_idle();
        desel_tick();
        chk("R11 cpu start reads", rdata, mdl[8'h10]);
        tick();
        read_single(8'h10, "R11 no write");
        order_ilv = 0;
        ld_ctl_n = 0; addr = 8'h40;
        tick();
        ld_ctl_n = 1; ce_n = 1; ld_cpu_n = 0; adv_n = 0;
        tick();
        chk("R11 gated strobe continues", rdata, mdl[8'h40]);
        ld_cpu_n = 1;
        desel_tick();
        chk("R11 next burst word", rdata, mdl[8'h41]);
        tick();
    endtask

    task automatic t_deselect();
        ld_ctl_n = 0; sel_lo_n = 1; addr = 8'h20; gw_n = 0; wdata = '0;
        tick();
        drive_idle();
        gw_n = 0; wdata = '0; adv_n = 0;
        tick();
        drive_idle();
        read_single(8'h20, "R12 deselect writes nothing");
        ld_ctl_n = 0; addr = 8'h21;
        tick();
        sel_hi = 0;
        tick();
        chk("R12 pipeline word", rdata, mdl[8'h21]);
        drive_idle();
        tick();
        chk("R12 low one edge later", {31'd0, rvalid}, 32'd0);
    endtask

    task automatic t_sleep();
        do_write(8'h30, 18'h2C0DE, 1'b0, 1'b1, 2'b11);
        ld_ctl_n = 0; addr = 8'h30;
        tick();
        ld_ctl_n = 0; ce_n = 1;
        tick();
        chk("R5 before sleep", {31'd0, rvalid}, 32'd1);
        sleep_i = 1;
        #1;
        chk("R9 sleep hides now", {31'd0, rvalid}, 32'd0);
        ce_n = 0; ld_ctl_n = 0; gw_n = 0; wdata = '0; addr = 8'h30;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R9 no output in sleep", {31'd0, rvalid}, 32'd0);
        end
        sleep_i = 0; gw_n = 1;
        tick();
        chk("R10 wake edge output", {31'd0, rvalid}, 32'd0);
        desel_tick();
        chk("R10 wake was deselect", {31'd0, rvalid}, 32'd0);
        read_single(8'h30, "R9 contents kept");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        drive_idle();
        order_ilv = 0;
        rst_n = 0;
        repeat (3) tick();
        t_reset();
        rst_n = 1;
        tick();
        t_reset();
        t_global_write();
        t_byte_write();
        t_gate_blocks();
        for (int a = 0; a < 4; a++) do_write(8'h40 + 8'(a), 18'h01100 + 18'(a * 18'h10011), 1'b0, 1'b1, 2'b11);
        t_burst(8'h42, 1'b0, "linear");
        t_burst(8'h41, 1'b1, "interleaved");
        t_burst(8'h43, 1'b1, "interleaved top");
        t_suspend();
        t_write_blank();
        t_oe();
        t_cpu();
        t_deselect();
        t_sleep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule